// File: doc/BRIEF.md
# Debug Trigger Match Unit

A bank of hardware breakpoint and watchpoint comparators that sits beside a processor core's debug logic. It holds a parameterised number of trigger slots (four by default). Each slot has a control word and a compare value, loaded through a slot-select register and two write strobes that share one write-data bus.

On every cycle the core presents a query: an operation kind (fetch/execute, store, load), the current privilege level, an address, a data value, a 32-bit-mode flag and a halted-in-debug flag. In the same cycle the unit reports whether any slot fired and the index of the lowest slot that fired. Each slot filters by operation and privilege, chooses address or data as its operand, and compares in one of six modes. Adjacent slots can be chained so that a group only fires when every member matches. The action field is stored but not acted on here.

Top module: `trig_match_unit`

## Requirements
- R1: After reset every slot's control word and compare value are zero, so no query produces `hit_o`=1 until a slot is configured.
- R2: A cycle with `sel_we_i` loads the slot selector from `wdata_i`. A cycle with `ctrl_we_i` or `cmp_we_i` writes the control word or the compare value of the selected slot only. Control word bits: 0 execute enable, 1 store enable, 2 load enable, 3 machine, 4 hypervisor, 5 supervisor, 6 user, 7 operand select, 8 chain, 11:9 mode, 15:12 action (stored only).
- R3: While `halted_i`=1, `hit_o`=0 whatever the configuration.
- R4: A slot cannot fire when its enable for `op_i` (0 execute, 1 store, 2 load) is clear, or when its enable for `priv_i` (0 user, 1 supervisor, 2 hypervisor, 3 machine) is clear. `op_i`=3 never fires any slot.
- R5: With operand select set, the slot compares `data_i`. With it clear, the slot compares `addr_i`.
- R6: With `narrow_i`=1, the operand's bits above bit 31 are cleared before comparison. The compare value is not truncated.
- R7: Mode 0 (equal) fires when the operand equals the compare value.
- R8: Mode 2 fires when operand >= compare value, and mode 3 fires when operand < compare value. Both comparisons are unsigned.
- R9: Mode 1 counts the run of ones n at the bottom of the compare value and fires when the operand and the compare value agree in every bit from n upward. An all-ones compare value matches any operand.
- R10: Mode 4 uses mask = compare >> H and fires when (operand & mask) == (compare & mask). Mode 5 fires when ((operand >> H) & mask) == (compare & mask). H is XLEN/2, or 16 when `narrow_i`=1.
- R11: Mode codes 6 and 7 never fire.
- R12: `hit_idx_o` is the lowest slot that fires with its chain bit clear and is not suppressed. When `hit_o`=0, `hit_idx_o` is 0.
- R13: A firing slot with chain set does not report and passes on to the next slot. A chained slot that does not fire suppresses every following slot up to and including the next slot with chain clear. A chain left open at the last slot never reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Load the slot selector from wdata_i |
| ctrl_we_i | input | 1 | Write the control word of the selected slot |
| cmp_we_i | input | 1 | Write the compare value of the selected slot |
| wdata_i | input | XLEN | Configuration write data |
| op_i | input | 2 | Operation kind of the query |
| priv_i | input | 2 | Privilege level of the query |
| addr_i | input | XLEN | Query address |
| data_i | input | XLEN | Query data |
| narrow_i | input | 1 | 32-bit mode: truncate the operand |
| halted_i | input | 1 | Hart halted in debug mode |
| hit_o | output | 1 | Some slot fired |
| hit_idx_o | output | IDXW | Index of the reporting slot |

## Verification
The hardest situation to reach is a chained slot that fails to match while a later slot in the same group does match, followed by an independent slot beyond the group that also matches. The suppression must end exactly at the group's last member. The bench builds this case by programming slot 0 as a chained data watch, slot 1 as its unchained address partner and slot 3 as an independent address watch. It then sweeps the data operand so that the group passes, fails, and hands the report on to slot 3. A chain left open at the last slot and the halted flag overriding a firing slot are driven as separate directed cases.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    MODE_EQ    = 3'd0,
    MODE_RANGE = 3'd1,
    MODE_GE    = 3'd2,
    MODE_LT    = 3'd3,
    MODE_MLO   = 3'd4,
    MODE_MHI   = 3'd5
  } mode_e;

  typedef struct packed {
    logic [3:0] action;
    logic [2:0] mode;
    logic       chain;
    logic       use_data;
    logic       en_u;
    logic       en_s;
    logic       en_h;
    logic       en_m;
    logic       en_load;
    logic       en_store;
    logic       en_exec;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 64,
  localparam int IDXW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sel_we_i,
  input  logic                            ctrl_we_i,
  input  logic                            cmp_we_i,
  input  logic [XLEN-1:0]                 wdata_i,
  output ctrl_t [NUM_SLOTS-1:0]           ctrl_o,
  output logic  [NUM_SLOTS-1:0][XLEN-1:0] cmp_o
);

  logic [IDXW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (sel_we_i) sel_q <= wdata_i[IDXW-1:0];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit_sel;
    assign hit_sel = (sel_q == IDXW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[i] <= '0;
        cmp_o[i]  <= '0;
      end else begin
        if (ctrl_we_i && hit_sel) ctrl_o[i] <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        if (cmp_we_i && hit_sel)  cmp_o[i]  <= wdata_i;
      end
    end
  end

  // R2: control words only change on a control strobe
  a_r2_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));

  // R2: compare values only change on a compare strobe
  a_r2_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_we_i |=> $stable(cmp_o));

endmodule

// File: rtl/trig_slot_cmp.sv
module trig_slot_cmp
  import trig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctrl_t           ctrl_i,
  input  logic [XLEN-1:0] cmp_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            narrow_i,
  output logic            fire_o
);

  localparam int SHW       = $clog2(XLEN) + 1;
  localparam int HALF_WIDE = XLEN / 2;
  localparam int HALF_NAR  = 16;

  logic            op_ok, priv_ok, cmp_ok;
  logic [XLEN-1:0] opnd, low_run, range_msk, half_msk, opnd_hi;
  logic [SHW-1:0]  half;
  logic            unused_action;

  assign unused_action = ^ctrl_i.action;

  always_comb begin
    unique case (op_e'(op_i))
      OP_EXEC:  op_ok = ctrl_i.en_exec;
      OP_STORE: op_ok = ctrl_i.en_store;
      OP_LOAD:  op_ok = ctrl_i.en_load;
      default:  op_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_U:  priv_ok = ctrl_i.en_u;
      PRIV_S:  priv_ok = ctrl_i.en_s;
      PRIV_H:  priv_ok = ctrl_i.en_h;
      default: priv_ok = ctrl_i.en_m;
    endcase
  end

  // operand choice and 32-bit truncation
  always_comb begin
    opnd = ctrl_i.use_data ? data_i : addr_i;
    for (int j = 32; j < XLEN; j++) begin
      if (narrow_i) opnd[j] = 1'b0;
    end
  end

  // trailing-ones run of the compare value
  always_comb begin
    logic run;
    run = 1'b1;
    for (int j = 0; j < XLEN; j++) begin
      run        = run & cmp_i[j];
      low_run[j] = run;
    end
  end

  assign range_msk = ~low_run;
  assign half      = narrow_i ? SHW'(HALF_NAR) : SHW'(HALF_WIDE);
  assign half_msk  = cmp_i >> half;
  assign opnd_hi   = opnd >> half;

  always_comb begin
    unique case (ctrl_i.mode)
      MODE_EQ:    cmp_ok = (opnd == cmp_i);
      MODE_RANGE: cmp_ok = ((opnd & range_msk) == (cmp_i & range_msk));
      MODE_GE:    cmp_ok = (opnd >= cmp_i);
      MODE_LT:    cmp_ok = (opnd < cmp_i);
      MODE_MLO:   cmp_ok = ((opnd & half_msk) == (cmp_i & half_msk));
      MODE_MHI:   cmp_ok = ((opnd_hi & half_msk) == (cmp_i & half_msk));
      default:    cmp_ok = 1'b0;
    endcase
  end

  assign fire_o = op_ok & priv_ok & cmp_ok;

  // R11: reserved mode codes never fire
  a_r11_bad_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode > 3'd5) |-> !fire_o);

  // R4: a disabled operation kind never fires
  a_r4_op_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 2'd0) && !ctrl_i.en_exec) |-> !fire_o);

endmodule

// File: rtl/trig_chain_resolve.sv
module trig_chain_resolve #(
  parameter int NUM_SLOTS = 4,
  localparam int IDXW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] fire_i,
  input  logic [NUM_SLOTS-1:0] chain_i,
  input  logic                 halted_i,
  output logic                 hit_o,
  output logic [IDXW-1:0]      idx_o
);

  logic            hit_raw;
  logic [IDXW-1:0] idx_raw;

  always_comb begin
    logic group_ok;
    group_ok = 1'b1;
    hit_raw  = 1'b0;
    idx_raw  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!hit_raw) begin
        if (!group_ok) begin
          group_ok = !chain_i[i];          // suppressed up to group end
        end else if (fire_i[i] && !chain_i[i]) begin
          hit_raw = 1'b1;
          idx_raw = IDXW'(i);
        end else if (chain_i[i] && !fire_i[i]) begin
          group_ok = 1'b0;
        end
      end
    end
  end

  assign hit_o = hit_raw & ~halted_i;
  assign idx_o = hit_o ? idx_raw : '0;

  // R12: reported slot fired with chain clear
  a_r12_idx_fired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (fire_i[idx_o] && !chain_i[idx_o]));

  // R3: halted suppresses everything
  a_r3_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> (!hit_o && idx_o == '0));

  // R13: nothing reports when every slot is chained
  a_r13_open_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&chain_i) |-> !hit_o);

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 64,
  localparam int IDXW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_we_i,
  input  logic            ctrl_we_i,
  input  logic            cmp_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            narrow_i,
  input  logic            halted_i,
  output logic            hit_o,
  output logic [IDXW-1:0] hit_idx_o
);

  ctrl_t [NUM_SLOTS-1:0]           ctrl_q;
  logic  [NUM_SLOTS-1:0][XLEN-1:0] cmp_q;
  logic  [NUM_SLOTS-1:0]           fire, chain;

  trig_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .XLEN(XLEN)) u_cfg (
    .clk_i, .rst_ni, .sel_we_i, .ctrl_we_i, .cmp_we_i, .wdata_i,
    .ctrl_o(ctrl_q), .cmp_o(cmp_q)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    trig_slot_cmp #(.XLEN(XLEN)) u_cmp (
      .clk_i, .rst_ni,
      .ctrl_i(ctrl_q[i]), .cmp_i(cmp_q[i]),
      .op_i, .priv_i, .addr_i, .data_i, .narrow_i,
      .fire_o(fire[i])
    );
    assign chain[i] = ctrl_q[i].chain;
  end

  trig_chain_resolve #(.NUM_SLOTS(NUM_SLOTS)) u_res (
    .clk_i, .rst_ni,
    .fire_i(fire), .chain_i(chain), .halted_i,
    .hit_o, .idx_o(hit_idx_o)
  );

  // R4: no operation code never fires
  a_r4_no_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd3) |-> !hit_o);

endmodule

// File: tb/trig_match_unit_test.sv
`timescale 1ns/1ps
module trig_match_unit_test;

  localparam int XLEN = 64;
  localparam int N    = 4;

  typedef struct packed {
    logic [15:0]     ctrl;
    logic [63:0]     cmp;
    logic [1:0]      op;
    logic [1:0]      priv;
    logic [63:0]     addr;
    logic [63:0]     data;
    logic            narrow;
    logic            hit;
    logic [1:0]      idx;
    logic [3:0]      rq;
  } vec_t;

  // all vectors program slot 0 only
  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{16'h007F, 64'h1000, 2'd0, 2'd3, 64'h1000, 64'h0, 1'b0, 1'b1, 2'd0, 4'd7},   // R7 equal hit
    '{16'h007F, 64'h1000, 2'd0, 2'd3, 64'h1004, 64'h0, 1'b0, 1'b0, 2'd0, 4'd7},   // R7 equal miss
    '{16'h00FF, 64'hAB,   2'd2, 2'd3, 64'hAB,   64'h12, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 data selected, addr ignored
    '{16'h00FF, 64'hAB,   2'd2, 2'd3, 64'h0,    64'hAB, 1'b0, 1'b1, 2'd0, 4'd5},  // R5 data hit
    '{16'h007E, 64'h40,   2'd0, 2'd3, 64'h40,   64'h0, 1'b0, 1'b0, 2'd0, 4'd4},   // R4 exec disabled
    '{16'h007E, 64'h40,   2'd1, 2'd3, 64'h40,   64'h0, 1'b0, 1'b1, 2'd0, 4'd4},   // R4 store enabled
    '{16'h003F, 64'h40,   2'd2, 2'd0, 64'h40,   64'h0, 1'b0, 1'b0, 2'd0, 4'd4},   // R4 user disabled
    '{16'h003F, 64'h40,   2'd2, 2'd1, 64'h40,   64'h0, 1'b0, 1'b1, 2'd0, 4'd4},   // R4 supervisor ok
    '{16'h007F, 64'h40,   2'd3, 2'd3, 64'h40,   64'h0, 1'b0, 1'b0, 2'd0, 4'd4},   // R4 op code 3
    '{16'h047F, 64'h100,  2'd0, 2'd3, 64'h100,  64'h0, 1'b0, 1'b1, 2'd0, 4'd8},   // R8 ge equal
    '{16'h047F, 64'h100,  2'd0, 2'd3, 64'hFF,   64'h0, 1'b0, 1'b0, 2'd0, 4'd8},   // R8 ge below
    '{16'h047F, 64'h100,  2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b1, 2'd0, 4'd8}, // R8 unsigned
    '{16'h067F, 64'h100,  2'd0, 2'd3, 64'hFF,   64'h0, 1'b0, 1'b1, 2'd0, 4'd8},   // R8 lt below
    '{16'h067F, 64'h100,  2'd0, 2'd3, 64'h100,  64'h0, 1'b0, 1'b0, 2'd0, 4'd8},   // R8 lt equal
    '{16'h067F, 64'h100,  2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0, 2'd0, 4'd8}, // R8 unsigned
    '{16'h027F, 64'h1007, 2'd0, 2'd3, 64'h1005, 64'h0, 1'b0, 1'b1, 2'd0, 4'd9},   // R9 inside range
    '{16'h027F, 64'h1007, 2'd0, 2'd3, 64'h1008, 64'h0, 1'b0, 1'b0, 2'd0, 4'd9},   // R9 outside range
    '{16'h027F, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd3, 64'h1234_5678, 64'h0, 1'b0, 1'b1, 2'd0, 4'd9}, // R9 all ones
    '{16'h007F, 64'h8000_0000, 2'd0, 2'd3, 64'hFFFF_FFFF_8000_0000, 64'h0, 1'b1, 1'b1, 2'd0, 4'd6}, // R6 truncated
    '{16'h007F, 64'h8000_0000, 2'd0, 2'd3, 64'hFFFF_FFFF_8000_0000, 64'h0, 1'b0, 1'b0, 2'd0, 4'd6}, // R6 full width
    '{16'h087F, 64'h0000_00FF_0000_0012, 2'd0, 2'd3, 64'h3312, 64'h0, 1'b0, 1'b1, 2'd0, 4'd10}, // R10 low hit
    '{16'h087F, 64'h0000_00FF_0000_0012, 2'd0, 2'd3, 64'h13,   64'h0, 1'b0, 1'b0, 2'd0, 4'd10}, // R10 low miss
    '{16'h0A7F, 64'h0000_00FF_0000_0034, 2'd0, 2'd3, 64'h0000_0034_0000_0000, 64'h0, 1'b0, 1'b1, 2'd0, 4'd10}, // R10 high hit
    '{16'h0A7F, 64'h0000_00FF_0000_0034, 2'd0, 2'd3, 64'h34, 64'h0, 1'b0, 1'b0, 2'd0, 4'd10}, // R10 high miss
    '{16'h087F, 64'h00FF_0012, 2'd0, 2'd3, 64'h5512, 64'h0, 1'b1, 1'b1, 2'd0, 4'd10}, // R10 narrow half
    '{16'h0C7F, 64'h0,    2'd0, 2'd3, 64'h0,    64'h0, 1'b0, 1'b0, 2'd0, 4'd11}    // R11 reserved mode
  };

  logic            clk, rst_n;
  logic            sel_we, ctrl_we, cmp_we;
  logic [XLEN-1:0] wdata, addr, data;
  logic [1:0]      op, priv;
  logic            narrow, halted;
  logic            hit;
  logic [1:0]      hit_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  trig_match_unit #(.NUM_SLOTS(N), .XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_we_i(sel_we), .ctrl_we_i(ctrl_we), .cmp_we_i(cmp_we), .wdata_i(wdata),
    .op_i(op), .priv_i(priv), .addr_i(addr), .data_i(data),
    .narrow_i(narrow), .halted_i(halted),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic exp_hit, input logic [1:0] exp_idx);
    n_chk++;
    if (hit !== exp_hit || hit_idx !== exp_idx) begin
      n_err++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
               tag, hit, hit_idx, exp_hit, exp_idx);
    end
  endtask

  task automatic wr_slot(input int s, input logic [15:0] c, input logic [63:0] v);
    @(negedge clk); sel_we = 1'b1; wdata = XLEN'(s);
    @(negedge clk); sel_we = 1'b0; ctrl_we = 1'b1; wdata = XLEN'(c);
    @(negedge clk); ctrl_we = 1'b0; cmp_we = 1'b1; wdata = v;
    @(negedge clk); cmp_we = 1'b0; wdata = '0;
  endtask

  task automatic query(input logic [1:0] o, input logic [1:0] p,
                       input logic [63:0] a, input logic [63:0] d, input logic nr);
    @(negedge clk);
    op = o; priv = p; addr = a; data = d; narrow = nr;
    #1;
  endtask

  task automatic clear_all();
    for (int s = 0; s < N; s++) wr_slot(s, 16'h0, 64'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_we = 0; ctrl_we = 0; cmp_we = 0; wdata = '0;
    op = 2'd0; priv = 2'd3; addr = '0; data = '0; narrow = 0; halted = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every slot empty after reset, even an all-zero equal query
    query(2'd0, 2'd3, 64'h0, 64'h0, 1'b0);
    check("R1 reset exec", 1'b0, 2'd0);
    query(2'd2, 2'd0, 64'h0, 64'h0, 1'b0);
    check("R1 reset load", 1'b0, 2'd0);

    // table walk on slot 0
    for (int k = 0; k < NV; k++) begin
      wr_slot(0, VEC[k].ctrl, VEC[k].cmp);
      query(VEC[k].op, VEC[k].priv, VEC[k].addr, VEC[k].data, VEC[k].narrow);
      check($sformatf("R%0d vec%0d", VEC[k].rq, k), VEC[k].hit, VEC[k].idx);
    end
    clear_all();

    // R2 and R12: slots 1 and 3 equal on 0x500, lowest wins
    wr_slot(3, 16'h007F, 64'h500);
    query(2'd0, 2'd3, 64'h500, 64'h0, 1'b0);
    check("R2 slot3 written", 1'b1, 2'd3);
    wr_slot(1, 16'h007F, 64'h500);
    query(2'd0, 2'd3, 64'h500, 64'h0, 1'b0);
    check("R12 lowest index", 1'b1, 2'd1);

    // R3: halted overrides a firing slot
    halted = 1'b1;
    query(2'd0, 2'd3, 64'h500, 64'h0, 1'b0);
    check("R3 halted", 1'b0, 2'd0);
    halted = 1'b0;

    // R13: slot0 chained data watch 0xD0, slot1 address 0x500, slot3 address 0x500
    wr_slot(0, 16'h01FF, 64'hD0);
    query(2'd0, 2'd3, 64'h500, 64'hD0, 1'b0);
    check("R13 group passes", 1'b1, 2'd1);
    query(2'd0, 2'd3, 64'h500, 64'hD1, 1'b0);
    check("R13 group suppressed, slot3 reports", 1'b1, 2'd3);
    query(2'd0, 2'd3, 64'h501, 64'hD0, 1'b0);
    check("R13 partner miss", 1'b0, 2'd0);

    // R13: open chain at the last slot never reports
    clear_all();
    wr_slot(3, 16'h017F, 64'h700);
    query(2'd0, 2'd3, 64'h700, 64'h0, 1'b0);
    check("R13 open chain at end", 1'b0, 2'd0);
    wr_slot(3, 16'h007F, 64'h700);
    query(2'd0, 2'd3, 64'h700, 64'h0, 1'b0);
    check("R13 chain cleared", 1'b1, 2'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule